// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two independent direction predictors and a selector. The first predictor uses the outcomes of the most recent branches across the whole program. The second uses the recent outcome pattern of the branch itself. A table of small saturating counters, indexed by branch address, decides for each branch which of the two predictors to trust. None of the tables carries an address tag, so branches whose index bits match share entries.

The fetch side presents a branch address on the predict port and receives a taken bit at once, without a clock edge. It also receives the global history and local pattern that were used, and keeps them with the branch. When the branch resolves, the execute side returns the address, the real outcome and those two saved indices on the update port. The counters, both histories and the selector change on that clock edge.

Each 2-bit direction counter moves through four states: STRONG_NT, WEAK_NT, WEAK_T and STRONG_T. A taken outcome steps one state toward STRONG_T and a not-taken outcome steps one state toward STRONG_NT, saturating at both ends. The selector has its own four states, SEL_STRONG_GLB, SEL_WEAK_GLB, SEL_WEAK_LOC and SEL_STRONG_LOC. It steps toward the local end when only the local predictor was right, steps toward the global end when only the global predictor was right, and holds when both were right or both were wrong. The local predictor uses 3-bit saturating counters, 0 to 7, where values 4 and above mean taken.

Top module: `tournament_predictor`

## Requirements
- R1: After reset both histories read zero, every 2-bit direction counter is WEAK_NT (01), every local counter is 3 (011), and every selector entry is SEL_WEAK_GLB (01). So pred_taken, pred_global_dir, pred_local_dir and pred_use_local are all 0.
- R2: pred_global_dir is bit 1 of the 2-bit counter selected by the current global history. The counter steps up on a taken update and down on a not-taken update, saturating at 0 and 3.
- R3: A 2-bit counter in STRONG_T (11) still predicts taken after one not-taken update and predicts not-taken only after a second one.
- R4: pred_lhist is the local history entry selected by pred_pc bits [11:2]. Each update shifts the actual outcome into bit 0 of the entry selected by upd_pc bits [11:2].
- R5: pred_local_dir is bit 2 of the 3-bit counter selected by pred_lhist. The counter saturates at 7 and at 0 and does not wrap.
- R6: pred_gidx is the global history. Each update shifts the actual outcome into bit 0, and the oldest outcome drops out of bit 11.
- R7: The selector entry is chosen by pc bits [13:2]. pred_use_local is its bit 1. On update the entry moves one step toward the predictor that was right when the two disagree, and holds when they agree.
- R8: pred_taken equals pred_local_dir when pred_use_local is 1, and pred_global_dir otherwise.
- R9: Branches whose addresses differ only above the index bits share the same local history entry and selector entry.
- R10: While upd_valid is low, no counter, history or selector entry changes.
- R11: An update trains the global counter at upd_gidx and the local counter at upd_lhist, as given on the port, not the current histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Final taken guess |
| pred_use_local | output | 1 | Selector currently favours the local predictor |
| pred_global_dir | output | 1 | Direction from the global predictor |
| pred_local_dir | output | 1 | Direction from the local predictor |
| pred_gidx | output | GHIST_W | Global history used for this prediction |
| pred_lhist | output | LHIST_W | Local pattern used for this prediction |
| upd_valid | input | 1 | Apply a resolved outcome on this edge |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_gidx | input | GHIST_W | Global history saved at prediction |
| upd_lhist | input | LHIST_W | Local pattern saved at prediction |

## Verification
The assertions assume that, whenever pred_pc is unchanged across an update, pred_lhist reflects only the shift made by that update. This holds because updates are serialised one per edge and the only writer of a local history entry is the update port. The history checks compare pred_gidx and pred_lhist one cycle after an update with the values they had before it, so the stimulus changes inputs only on falling edges. It also keeps pred_pc fixed across any update whose effect is to be observed. Normal stimulus returns the snapshot from the prediction of the same branch. The directed cases deliberately return other indices, to show that training follows the port and not the live history.

// File: rtl/tpred_pkg.sv
package tpred_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr2_e;

    typedef enum logic [1:0] {
        SEL_STRONG_GLB = 2'd0,
        SEL_WEAK_GLB   = 2'd1,
        SEL_WEAK_LOC   = 2'd2,
        SEL_STRONG_LOC = 2'd3
    } sel_e;

    function automatic ctr2_e ctr2_step(input ctr2_e cur, input logic taken);
        ctr2_e nxt;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr2_taken(input ctr2_e cur);
        return (cur == CTR_WEAK_T) || (cur == CTR_STRONG_T);
    endfunction

    function automatic sel_e sel_step(input sel_e cur, input logic glb_ok, input logic loc_ok);
        sel_e nxt;
        nxt = cur;
        if (glb_ok && !loc_ok) begin
            unique case (cur)
                SEL_STRONG_GLB: nxt = SEL_STRONG_GLB;
                SEL_WEAK_GLB:   nxt = SEL_STRONG_GLB;
                SEL_WEAK_LOC:   nxt = SEL_WEAK_GLB;
                SEL_STRONG_LOC: nxt = SEL_WEAK_LOC;
            endcase
        end else if (loc_ok && !glb_ok) begin
            unique case (cur)
                SEL_STRONG_GLB: nxt = SEL_WEAK_GLB;
                SEL_WEAK_GLB:   nxt = SEL_WEAK_LOC;
                SEL_WEAK_LOC:   nxt = SEL_STRONG_LOC;
                SEL_STRONG_LOC: nxt = SEL_STRONG_LOC;
            endcase
        end
        return nxt;
    endfunction

    function automatic logic sel_local(input sel_e cur);
        return (cur == SEL_WEAK_LOC) || (cur == SEL_STRONG_LOC);
    endfunction

endpackage

// File: rtl/tpred_global.sv
module tpred_global
    import tpred_pkg::*;
#(
    parameter int unsigned HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [HIST_W-1:0] upd_idx,
    input  logic              upd_taken,
    output logic [HIST_W-1:0] hist_o,
    output logic              pred_dir_o,
    output logic              upd_dir_o
);
    localparam int unsigned DEPTH = 1 << HIST_W;

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_nxt;
    ctr2_e             pht [DEPTH];
    ctr2_e             pht_nxt;

    always_comb begin
        hist_nxt = {hist_q[HIST_W-2:0], upd_taken};
        pht_nxt  = ctr2_step(pht[upd_idx], upd_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                pht[i] <= CTR_WEAK_NT;
            end
        end else if (upd_en) begin
            hist_q       <= hist_nxt;
            pht[upd_idx] <= pht_nxt;
        end
    end

    always_comb begin
        hist_o     = hist_q;
        pred_dir_o = ctr2_taken(pht[hist_q]);
        upd_dir_o  = ctr2_taken(pht[upd_idx]);
    end

endmodule

// File: rtl/tpred_local.sv
module tpred_local #(
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned HIST_W = 10,
    parameter int unsigned CTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] hist_o,
    output logic              pred_dir_o,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [HIST_W-1:0] upd_pat,
    input  logic              upd_taken,
    output logic              upd_dir_o
);
    localparam int unsigned      LHT_DEPTH = 1 << IDX_W;
    localparam int unsigned      CTR_DEPTH = 1 << HIST_W;
    localparam logic [CTR_W-1:0] CTR_MAX   = '1;
    localparam logic [CTR_W-1:0] CTR_INIT  = CTR_MAX >> 1;
    localparam logic [CTR_W-1:0] CTR_ONE   = {{(CTR_W-1){1'b0}}, 1'b1};

    logic [HIST_W-1:0] lht [LHT_DEPTH];
    logic [CTR_W-1:0]  cnt [CTR_DEPTH];
    logic [HIST_W-1:0] lht_nxt;
    logic [CTR_W-1:0]  cnt_cur;
    logic [CTR_W-1:0]  cnt_nxt;

    always_comb begin
        lht_nxt = {lht[upd_idx][HIST_W-2:0], upd_taken};
        cnt_cur = cnt[upd_pat];
        if (upd_taken) begin
            cnt_nxt = (cnt_cur == CTR_MAX) ? cnt_cur : cnt_cur + CTR_ONE;
        end else begin
            cnt_nxt = (cnt_cur == '0) ? cnt_cur : cnt_cur - CTR_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LHT_DEPTH; i++) begin
                lht[i] <= '0;
            end
            for (int j = 0; j < CTR_DEPTH; j++) begin
                cnt[j] <= CTR_INIT;
            end
        end else if (upd_en) begin
            lht[upd_idx] <= lht_nxt;
            cnt[upd_pat] <= cnt_nxt;
        end
    end

    always_comb begin
        hist_o     = lht[rd_idx];
        pred_dir_o = cnt[lht[rd_idx]][CTR_W-1];
        upd_dir_o  = cnt_cur[CTR_W-1];
    end

endmodule

// File: rtl/tpred_chooser.sv
module tpred_chooser
    import tpred_pkg::*;
#(
    parameter int unsigned IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             use_local_o,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             glb_ok,
    input  logic             loc_ok
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    sel_e tbl [DEPTH];
    sel_e tbl_nxt;

    always_comb begin
        tbl_nxt = sel_step(tbl[upd_idx], glb_ok, loc_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= SEL_WEAK_GLB;
            end
        end else if (upd_en) begin
            tbl[upd_idx] <= tbl_nxt;
        end
    end

    always_comb begin
        use_local_o = sel_local(tbl[rd_idx]);
    end

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned PC_LSB    = 2,
    parameter int unsigned GHIST_W   = 12,
    parameter int unsigned LHT_IDX_W = 10,
    parameter int unsigned LHIST_W   = 10,
    parameter int unsigned LCTR_W    = 3,
    parameter int unsigned SEL_IDX_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_W-1:0]    pred_pc,
    output logic               pred_taken,
    output logic               pred_use_local,
    output logic               pred_global_dir,
    output logic               pred_local_dir,
    output logic [GHIST_W-1:0] pred_gidx,
    output logic [LHIST_W-1:0] pred_lhist,
    input  logic               upd_valid,
    input  logic [PC_W-1:0]    upd_pc,
    input  logic               upd_taken,
    input  logic [GHIST_W-1:0] upd_gidx,
    input  logic [LHIST_W-1:0] upd_lhist
);
    localparam int unsigned LHT_HI = PC_LSB + LHT_IDX_W - 1;
    localparam int unsigned SEL_HI = PC_LSB + SEL_IDX_W - 1;

    logic [LHT_IDX_W-1:0] rd_lht_idx;
    logic [LHT_IDX_W-1:0] upd_lht_idx;
    logic [SEL_IDX_W-1:0] rd_sel_idx;
    logic [SEL_IDX_W-1:0] upd_sel_idx;
    logic                 glb_upd_dir;
    logic                 loc_upd_dir;
    logic                 glb_ok;
    logic                 loc_ok;
    logic                 unused_pc_bits;

    assign rd_lht_idx     = pred_pc[LHT_HI:PC_LSB];
    assign upd_lht_idx    = upd_pc[LHT_HI:PC_LSB];
    assign rd_sel_idx     = pred_pc[SEL_HI:PC_LSB];
    assign upd_sel_idx    = upd_pc[SEL_HI:PC_LSB];
    assign unused_pc_bits = ^{pred_pc, upd_pc};

    tpred_global #(
        .HIST_W (GHIST_W)
    ) u_global (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (upd_valid),
        .upd_idx    (upd_gidx),
        .upd_taken  (upd_taken),
        .hist_o     (pred_gidx),
        .pred_dir_o (pred_global_dir),
        .upd_dir_o  (glb_upd_dir)
    );

    tpred_local #(
        .IDX_W  (LHT_IDX_W),
        .HIST_W (LHIST_W),
        .CTR_W  (LCTR_W)
    ) u_local (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (rd_lht_idx),
        .hist_o     (pred_lhist),
        .pred_dir_o (pred_local_dir),
        .upd_en     (upd_valid),
        .upd_idx    (upd_lht_idx),
        .upd_pat    (upd_lhist),
        .upd_taken  (upd_taken),
        .upd_dir_o  (loc_upd_dir)
    );

    always_comb begin
        glb_ok = (glb_upd_dir == upd_taken);
        loc_ok = (loc_upd_dir == upd_taken);
    end

    tpred_chooser #(
        .IDX_W (SEL_IDX_W)
    ) u_chooser (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (rd_sel_idx),
        .use_local_o (pred_use_local),
        .upd_en      (upd_valid),
        .upd_idx     (upd_sel_idx),
        .glb_ok      (glb_ok),
        .loc_ok      (loc_ok)
    );

    always_comb begin
        pred_taken = pred_use_local ? pred_local_dir : pred_global_dir;
    end

endmodule

// File: rtl/tpred_checker.sv
module tpred_checker #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned PC_LSB    = 2,
    parameter int unsigned GHIST_W   = 12,
    parameter int unsigned LHT_IDX_W = 10,
    parameter int unsigned LHIST_W   = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    pred_pc,
    input logic               pred_taken,
    input logic [GHIST_W-1:0] pred_gidx,
    input logic [LHIST_W-1:0] pred_lhist,
    input logic               upd_valid,
    input logic [PC_W-1:0]    upd_pc,
    input logic               upd_taken
);
    localparam int unsigned LHT_HI = PC_LSB + LHT_IDX_W - 1;

    logic same_entry;
    assign same_entry = (pred_pc[LHT_HI:PC_LSB] == upd_pc[LHT_HI:PC_LSB]);

    AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (pred_gidx == {$past(pred_gidx[GHIST_W-2:0]), $past(upd_taken)})); // R6

    AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(pred_gidx)); // R10

    AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && same_entry) |=>
            ($stable(pred_pc) -> (pred_lhist == {$past(pred_lhist[LHIST_W-2:0]), $past(upd_taken)}))); // R4

    AST_LHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(pred_pc) -> $stable(pred_lhist))); // R10

    AST_PRED_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_taken)); // R8

endmodule

bind tournament_predictor tpred_checker #(
    .PC_W      (PC_W),
    .PC_LSB    (PC_LSB),
    .GHIST_W   (GHIST_W),
    .LHT_IDX_W (LHT_IDX_W),
    .LHIST_W   (LHIST_W)
) u_tpred_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .pred_gidx  (pred_gidx),
    .pred_lhist (pred_lhist),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken)
);

// File: tb/sim_tournament_predictor.sv
module sim_tournament_predictor;

    localparam int GN = 4096;
    localparam int HN = 1024;
    localparam int LN = 1024;
    localparam int CN = 4096;
    localparam int NVEC = 16;

    // {pc, taken}
    localparam logic [32:0] VEC [NVEC] = '{
        {32'h0000_0100, 1'b1}, {32'h0000_0104, 1'b0}, {32'h0000_0100, 1'b1}, {32'h0000_2000, 1'b1},
        {32'h0000_0100, 1'b0}, {32'h0000_0104, 1'b0}, {32'h0000_2000, 1'b0}, {32'h0000_0100, 1'b1},
        {32'h0001_0100, 1'b1}, {32'h0000_0104, 1'b1}, {32'h0000_0100, 1'b1}, {32'h0000_2000, 1'b1},
        {32'h0000_0ffc, 1'b0}, {32'h0000_0100, 1'b0}, {32'h0000_0104, 1'b1}, {32'h0000_0ffc, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken, pred_use_local, pred_global_dir, pred_local_dir;
    logic [11:0] pred_gidx;
    logic [9:0]  pred_lhist;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [11:0] upd_gidx = '0;
    logic [9:0]  upd_lhist = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int m_g [GN];
    int m_l [LN];
    int m_lht [HN];
    int m_ch [CN];
    int m_gh;

    always #10 clk = ~clk;

    tournament_predictor u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_use_local(pred_use_local), .pred_global_dir(pred_global_dir),
        .pred_local_dir(pred_local_dir), .pred_gidx(pred_gidx), .pred_lhist(pred_lhist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_gidx(upd_gidx), .upd_lhist(upd_lhist)
    );

    function automatic int hidx(input logic [31:0] pc);
        return int'((pc >> 2) & (HN - 1));
    endfunction

    function automatic int cidx(input logic [31:0] pc);
        return int'((pc >> 2) & (CN - 1));
    endfunction

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic model_init();
        for (int i = 0; i < GN; i++) m_g[i] = 1;
        for (int i = 0; i < LN; i++) m_l[i] = 3;
        for (int i = 0; i < HN; i++) m_lht[i] = 0;
        for (int i = 0; i < CN; i++) m_ch[i] = 1;
        m_gh = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        model_init();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic model_update(input logic [31:0] pc, input bit tk, input int gi, input int lp);
        bit gok, lok;
        gok = ((m_g[gi] >= 2) == tk);
        lok = ((m_l[lp] >= 4) == tk);
        if (tk) begin
            if (m_g[gi] < 3) m_g[gi]++;
            if (m_l[lp] < 7) m_l[lp]++;
        end else begin
            if (m_g[gi] > 0) m_g[gi]--;
            if (m_l[lp] > 0) m_l[lp]--;
        end
        if (lok && !gok && m_ch[cidx(pc)] < 3) m_ch[cidx(pc)]++;
        if (gok && !lok && m_ch[cidx(pc)] > 0) m_ch[cidx(pc)]--;
        m_gh = ((m_gh << 1) | int'(tk)) & (GN - 1);
        m_lht[hidx(pc)] = ((m_lht[hidx(pc)] << 1) | int'(tk)) & (LN - 1);
    endtask

    // Called just after a falling edge; returns just after the next falling edge.
    task automatic apply_upd(input logic [31:0] pc, input bit tk, input int gi, input int lp);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = tk;
        upd_gidx  = gi[11:0];
        upd_lhist = lp[9:0];
        @(posedge clk);
        model_update(pc, tk, gi, lp);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic check_model(input string where);
        int gd, ld, ul;
        gd = (m_g[m_gh] >= 2) ? 1 : 0;
        ld = (m_l[m_lht[hidx(pred_pc)]] >= 4) ? 1 : 0;
        ul = (m_ch[cidx(pred_pc)] >= 2) ? 1 : 0;
        chk(int'(pred_gidx), m_gh, {"R6 global history ", where});
        chk(int'(pred_lhist), m_lht[hidx(pred_pc)], {"R4 local history ", where});
        chk(int'(pred_global_dir), gd, {"R2 global dir ", where});
        chk(int'(pred_local_dir), ld, {"R5 local dir ", where});
        chk(int'(pred_use_local), ul, {"R7 selector ", where});
        chk(int'(pred_taken), ul ? ld : gd, {"R8 final ", where});
    endtask

    task automatic step(input logic [31:0] pc, input bit tk, input string where);
        pred_pc = pc;
        #1;
        check_model(where);
        apply_upd(pc, tk, m_gh, m_lht[hidx(pc)]);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        pred_pc = 32'h100;
        #1;
        chk(int'(pred_taken), 0, "R1 pred_taken after reset");
        chk(int'(pred_gidx), 0, "R1 global history after reset");
        chk(int'(pred_lhist), 0, "R1 local history after reset");
        chk(int'(pred_use_local), 0, "R1 selector after reset");
        chk(int'(pred_global_dir), 0, "R1 global dir after reset");
        chk(int'(pred_local_dir), 0, "R1 local dir after reset");

        // R11 / R3: train counter 0 via port index, clear history elsewhere
        apply_upd(32'h300, 1'b1, 0, 0);
        for (int i = 0; i < 12; i++) apply_upd(32'h300, 1'b0, 12'h5a5, 0);
        #1;
        chk(int'(pred_gidx), 0, "R6 history flushed by 12 not-taken");
        chk(int'(pred_global_dir), 1, "R11 counter at port index trained");
        apply_upd(32'h300, 1'b1, 0, 0);
        for (int i = 0; i < 12; i++) apply_upd(32'h300, 1'b0, 12'h5a5, 0);
        #1;
        chk(int'(pred_global_dir), 1, "R2 counter saturated taken");
        apply_upd(32'h300, 1'b0, 0, 0);
        #1;
        chk(int'(pred_global_dir), 1, "R3 one miss keeps taken");
        apply_upd(32'h300, 1'b0, 0, 0);
        #1;
        chk(int'(pred_global_dir), 0, "R3 second miss flips");

        // R5 local counter saturation
        do_reset();
        pred_pc = 32'h500;
        for (int i = 0; i < 5; i++) apply_upd(32'h600, 1'b1, 12'h0f0, 0);
        #1;
        chk(int'(pred_lhist), 0, "R4 untouched entry stays zero");
        chk(int'(pred_local_dir), 1, "R5 local counter taken at top");
        for (int i = 0; i < 4; i++) apply_upd(32'h600, 1'b0, 12'h0f0, 0);
        #1;
        chk(int'(pred_local_dir), 0, "R5 no wrap at 7");

        // R7 selector
        do_reset();
        pred_pc = 32'h700;
        apply_upd(32'h700, 1'b1, 12'h111, 0);
        #1;
        chk(int'(pred_use_local), 0, "R7 both wrong holds selector");
        apply_upd(32'h700, 1'b1, 12'h222, 0);
        #1;
        chk(int'(pred_use_local), 1, "R7 local right moves selector");
        pred_pc = 32'h704;
        #1;
        chk(int'(pred_use_local), 0, "R7 other entry unaffected");

        // R9 aliasing
        do_reset();
        apply_upd(32'h100, 1'b1, 0, 0);
        pred_pc = 32'h0001_0100;
        #1;
        chk(int'(pred_lhist), 1, "R9 aliased branch shares local history");

        // R10 no update while upd_valid low
        for (int i = 0; i < 5; i++) begin
            upd_pc = 32'h0001_0100;
            upd_taken = i[0];
            upd_gidx = 12'hfff;
            upd_lhist = 10'h3ff;
            @(negedge clk);
        end
        #1;
        chk(int'(pred_gidx), 1, "R10 global history held");
        chk(int'(pred_lhist), 1, "R10 local history held");
        chk(int'(pred_local_dir), 0, "R10 local counter held");

        // Vector table walked against the behavioural expectation
        do_reset();
        for (int v = 0; v < NVEC; v++) step(VEC[v][32:1], VEC[v][0], "vector");

        // Loop-like pattern and an alternating branch
        for (int it = 0; it < 40; it++) begin
            for (int k = 0; k < 4; k++) step(32'h400, (k != 3), "loop");
            step(32'h800, it[0], "alternating");
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule